// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block turns a binary32 or binary64 operand into a signed 32-bit or 64-bit integer. The rounding mode is chosen per operation by a 4-bit modifier. Modifier 0, and any code without a fixed meaning, falls back to the rounding mode currently in force. A 32-bit result replaces only the low half of a 64-bit destination register, and the upper half keeps its old contents. A 2-bit condition code describes the source operand, not the integer that comes out.

The conversion is sequential. A start pulse captures all operands. The mantissa is then shifted right one bit per cycle until the binary point sits at bit 0, and guard and sticky bits collect whatever falls off. One more cycle rounds the value, checks its range, merges it into the destination and raises a single-cycle done. Values out of range and NaNs saturate and raise the invalid flag.

Top module: `fp2int_conv`

## Requirements
- R1: After reset, busy and done are 0, and dst, cc, invalid and inexact are all 0.
- R2: The effective rounding mode is taken from modifier: 1 and 4 give nearest-even, 5 gives toward zero, 6 gives toward +infinity, 7 gives toward -infinity. 0, 2, 3 and 8 to 15 use cur_rmode, which is encoded 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R3: With src_dbl=1, src[63:0] holds a binary64 value. With src_dbl=0, src[31:0] holds a binary32 value and src[63:32] has no effect. An in-range source gives its value rounded to an integer in the effective mode, in two's complement.
- R4: With tgt_wide=1, dst is the full 64-bit result. With tgt_wide=0, dst[63:32] equals old_dst[63:32] as sampled at start, and dst[31:0] holds the 32-bit result.
- R5: cc is 3 for a NaN source, 0 for a zero of either sign, 1 for any other negative source and 2 for any other positive source, whatever the result.
- R6: A rounded value above the largest target integer, or below the smallest, sets invalid=1 and clears inexact. This includes infinities. The result saturates to 0x7FFF_FFFF or 0x8000_0000 (32-bit target), or to 0x7FFF_FFFF_FFFF_FFFF or 0x8000_0000_0000_0000 (64-bit target), following the sign.
- R7: A NaN source gives the most negative integer of the target width and sets invalid=1.
- R8: For an in-range result, inexact is 1 exactly when the source has a nonzero fraction that was discarded. Invalid and inexact are never 1 together.
- R9: busy is 1 from the cycle after an accepted start until done. done is a one-cycle pulse no later than 68 cycles after the start edge.
- R10: A start while busy=1 is ignored. The result that follows belongs to the operands accepted first, and no extra done follows.
- R11: dst, cc, invalid and inexact hold their values from one done until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| src | input | 64 | Source operand |
| src_dbl | input | 1 | 1 selects binary64, 0 selects binary32 in the low half |
| tgt_wide | input | 1 | 1 selects a 64-bit integer, 0 selects a 32-bit integer |
| modifier | input | 4 | Per-operation rounding selector |
| cur_rmode | input | 2 | Rounding mode currently in force |
| old_dst | input | 64 | Previous destination register contents |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| dst | output | 64 | New destination register value |
| cc | output | 2 | Condition code describing the source |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Inexact flag |

## Verification
The number of shift cycles depends on the source exponent: 63 minus the exponent, capped at 65, and zero for zeros, NaNs and out-of-range values. done therefore arrives between 2 and 67 cycles after the start edge. The bench does not predict that latency. After the cycle that follows start, where it expects busy high, it polls done on falling edges and checks that done arrived within the 68-cycle bound. All result fields are compared in the cycle done is high. One cycle later the bench checks that done has dropped, and after an idle gap it checks that the outputs have not moved.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int XLEN     = 64;
  localparam int MANT_W   = 53;
  localparam int EXP_W    = 13;
  localparam int CNT_W    = 7;
  localparam int PAD_W    = XLEN - MANT_W;
  localparam int MAX_SHIFT = XLEN + 1;

  typedef enum logic [1:0] {
    RM_NE = 2'd0,
    RM_TZ = 2'd1,
    RM_UP = 2'd2,
    RM_DN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic                     sign;
    logic                     nan;
    logic                     inf;
    logic                     zero;
    logic signed [EXP_W-1:0]  exp;
    logic [MANT_W-1:0]        mant;
  } fval_t;

  function automatic logic [1:0] f_class_cc(fval_t v);
    if (v.nan)       return 2'd3;
    else if (v.zero) return 2'd0;
    else if (v.sign) return 2'd1;
    else             return 2'd2;
  endfunction

  // Shift needed to bring the binary point (value = acc * 2^(exp-63)) to bit 0.
  function automatic logic [CNT_W-1:0] f_shift_count(logic signed [EXP_W-1:0] e);
    logic signed [EXP_W-1:0] d;
    d = 13'sd63 - e;
    if (e >= 13'sd63)      return '0;
    else if (e < -13'sd2)  return CNT_W'(MAX_SHIFT);
    else                   return d[CNT_W-1:0];
  endfunction

  function automatic logic f_round_up(rmode_e rm, logic neg, logic lsb,
                                      logic g, logic s);
    case (rm)
      RM_NE:   return g & (s | lsb);
      RM_TZ:   return 1'b0;
      RM_UP:   return (g | s) & ~neg;
      default: return (g | s) & neg;
    endcase
  endfunction

  // Largest magnitude allowed for the given sign and target width.
  function automatic logic [XLEN:0] f_limit(logic wide, logic neg);
    logic [XLEN:0] b;
    b = wide ? ((XLEN+1)'(1) << (XLEN-1)) : ((XLEN+1)'(1) << 31);
    return neg ? b : b - (XLEN+1)'(1);
  endfunction
endpackage

// File: rtl/fc_rmode_sel.sv
module fc_rmode_sel
  import fc_pkg::*;
(
  input  logic [3:0] modifier,
  input  logic [1:0] cur_rmode,
  output rmode_e     rm_eff
);
  always_comb begin
    case (modifier)
      4'd1, 4'd4: rm_eff = RM_NE;
      4'd5:       rm_eff = RM_TZ;
      4'd6:       rm_eff = RM_UP;
      4'd7:       rm_eff = RM_DN;
      default:    rm_eff = rmode_e'(cur_rmode);
    endcase
  end
endmodule

// File: rtl/fc_unpack.sv
module fc_unpack
  import fc_pkg::*;
(
  input  logic [XLEN-1:0] src,
  input  logic            is_dbl,
  output fval_t           fv
);
  logic [10:0] ef_d;
  logic [51:0] fr_d;
  logic [7:0]  ef_s;
  logic [22:0] fr_s;

  assign ef_d = src[62:52];
  assign fr_d = src[51:0];
  assign ef_s = src[30:23];
  assign fr_s = src[22:0];

  always_comb begin
    if (is_dbl) begin
      fv.sign = src[63];
      fv.nan  = (&ef_d) && (fr_d != '0);
      fv.inf  = (&ef_d) && (fr_d == '0);
      fv.zero = (ef_d == '0) && (fr_d == '0);
      fv.exp  = (ef_d == '0) ? -13'sd1022
                             : $signed({2'b00, ef_d}) - 13'sd1023;
      fv.mant = {(ef_d != '0), fr_d};
    end else begin
      fv.sign = src[31];
      fv.nan  = (&ef_s) && (fr_s != '0);
      fv.inf  = (&ef_s) && (fr_s == '0);
      fv.zero = (ef_s == '0) && (fr_s == '0);
      fv.exp  = (ef_s == '0) ? -13'sd126
                             : $signed({5'b00000, ef_s}) - 13'sd127;
      fv.mant = {(ef_s != '0), fr_s, 29'b0};
    end
  end
endmodule

// File: rtl/fc_align_shift.sv
module fc_align_shift
  import fc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  acc_in,
  input  logic [CW-1:0] cnt_in,
  output logic [W-1:0]  mag,
  output logic          guard,
  output logic          sticky,
  output logic          empty
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag    <= '0;
      cnt    <= '0;
      guard  <= 1'b0;
      sticky <= 1'b0;
    end else if (load) begin
      mag    <= acc_in;
      cnt    <= cnt_in;
      guard  <= 1'b0;
      sticky <= 1'b0;
    end else if (cnt != '0) begin
      sticky <= sticky | guard;
      guard  <= mag[0];
      mag    <= mag >> 1;
      cnt    <= cnt - 1'b1;
    end
  end

  assign empty = (cnt == '0);

  // R9: the shift count handed in never exceeds the cap that bounds latency
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_in <= CW'(MAX_SHIFT)));
  // R8: once a discarded one is seen, sticky holds until the next load
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !load) |=> sticky);
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [63:0]     src,
  input  logic            src_dbl,
  input  logic            tgt_wide,
  input  logic [3:0]      modifier,
  input  logic [1:0]      cur_rmode,
  input  logic [63:0]     old_dst,
  output logic            busy,
  output logic            done,
  output logic [63:0]     dst,
  output logic [1:0]      cc,
  output logic            invalid,
  output logic            inexact
);
  typedef enum logic {S_IDLE, S_SHIFT} state_e;
  state_e state;

  fval_t          fv;
  rmode_e         rm_eff;
  logic           accept;
  logic           big_in;
  logic [CNT_W-1:0] cnt_in;
  logic [XLEN-1:0]  acc_in;

  logic           sign_q, nan_q, big_q, wide_q;
  logic [1:0]     cc_q;
  rmode_e         rm_q;
  logic [63:0]    old_q;

  logic [XLEN-1:0] sh_mag;
  logic            sh_g, sh_s, sh_empty;
  logic            finalize;

  logic            rnd_up;
  logic [XLEN:0]   rnd_sum;
  logic            ovf;
  logic            inval_n;
  logic [63:0]     maxv, minv, res64, dst_n;

  fc_unpack u_unpack (.src(src), .is_dbl(src_dbl), .fv(fv));
  fc_rmode_sel u_rsel (.modifier(modifier), .cur_rmode(cur_rmode), .rm_eff(rm_eff));

  assign accept = start && (state == S_IDLE);
  assign big_in = fv.inf || (!fv.nan && (fv.exp >= 13'sd64));
  assign cnt_in = (fv.nan || big_in || fv.zero) ? '0 : f_shift_count(fv.exp);
  assign acc_in = {fv.mant, {PAD_W{1'b0}}};

  fc_align_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .acc_in(acc_in), .cnt_in(cnt_in),
    .mag(sh_mag), .guard(sh_g), .sticky(sh_s), .empty(sh_empty)
  );

  assign finalize = (state == S_SHIFT) && sh_empty;
  assign busy     = (state == S_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sign_q <= 1'b0;
      nan_q  <= 1'b0;
      big_q  <= 1'b0;
      wide_q <= 1'b0;
      cc_q   <= 2'd0;
      rm_q   <= RM_NE;
      old_q  <= '0;
    end else if (accept) begin
      state  <= S_SHIFT;
      sign_q <= fv.sign;
      nan_q  <= fv.nan;
      big_q  <= big_in;
      wide_q <= tgt_wide;
      cc_q   <= f_class_cc(fv);
      rm_q   <= rm_eff;
      old_q  <= old_dst;
    end else if (finalize) begin
      state  <= S_IDLE;
    end
  end

  // Rounding, range check and destination merge
  always_comb begin
    rnd_up  = f_round_up(rm_q, sign_q, sh_mag[0], sh_g, sh_s);
    rnd_sum = {1'b0, sh_mag} + {{XLEN{1'b0}}, rnd_up};
    ovf     = big_q || (rnd_sum > f_limit(wide_q, sign_q));
    inval_n = nan_q || ovf;
    maxv    = wide_q ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    minv    = wide_q ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    if (nan_q)       res64 = minv;
    else if (ovf)    res64 = sign_q ? minv : maxv;
    else if (sign_q) res64 = -rnd_sum[63:0];
    else             res64 = rnd_sum[63:0];
    dst_n = wide_q ? res64 : {old_q[63:32], res64[31:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      dst     <= '0;
      cc      <= 2'd0;
      invalid <= 1'b0;
      inexact <= 1'b0;
    end else begin
      done <= finalize;
      if (finalize) begin
        dst     <= dst_n;
        cc      <= cc_q;
        invalid <= inval_n;
        inexact <= !inval_n && (sh_g || sh_s);
      end
    end
  end

  // R9: done never lasts more than one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: captured operands cannot move while a conversion is running
  p_capture_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(old_q) && $stable(sign_q) && $stable(wide_q) && $stable(rm_q));
  // R4: a narrow result keeps the captured upper half
  p_upper_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |-> (dst[63:32] == old_q[63:32]));
  // R7: a NaN source reports invalid and cc 3
  p_nan_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nan_q) |-> (invalid && cc == 2'd3));
  // R8: invalid and inexact are exclusive
  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(invalid && inexact));
  // R6: a wide overflow lands on one of the two extreme integers
  p_sat_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid && wide_q) |->
      (dst == 64'h7FFF_FFFF_FFFF_FFFF || dst == 64'h8000_0000_0000_0000));
  // R11: results move only on the finishing cycle
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !finalize |=> ($stable(dst) && $stable(cc) && $stable(invalid) && $stable(inexact)));
endmodule

// File: tb/tb_fp2int_conv.sv
module tb_fp2int_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] src = '0;
  logic        src_dbl = 1'b0;
  logic        tgt_wide = 1'b0;
  logic [3:0]  modifier = '0;
  logic [1:0]  cur_rmode = '0;
  logic [63:0] old_dst = '0;
  logic        busy, done, invalid, inexact;
  logic [63:0] dst;
  logic [1:0]  cc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp2int_conv dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .src_dbl(src_dbl),
    .tgt_wide(tgt_wide), .modifier(modifier), .cur_rmode(cur_rmode),
    .old_dst(old_dst), .busy(busy), .done(done), .dst(dst), .cc(cc),
    .invalid(invalid), .inexact(inexact)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model: scaled integer arithmetic with 64 fraction bits.
  task automatic ref_conv(input logic [63:0] s, input logic dbl, input logic wide,
                          input logic [3:0] md, input logic [1:0] cur, input logic [63:0] old,
                          output logic [63:0] edst, output logic [1:0] ecc,
                          output logic einv, output logic einx);
    logic sg, isnan, isinf, iszero, up;
    int ef, bias, fb, emf, e;
    logic [52:0] man;
    logic [1:0] rm;
    logic [127:0] X;
    logic [63:0] ip, fr, val, maxv, minv;
    logic [64:0] mag, lim;
    if (dbl) begin
      sg = s[63]; ef = int'(s[62:52]); man = {1'b0, s[51:0]}; fb = 52; bias = 1023; emf = 2047;
    end else begin
      sg = s[31]; ef = int'(s[30:23]); man = {30'b0, s[22:0]}; fb = 23; bias = 127; emf = 255;
    end
    isnan  = (ef == emf) && (man != 0);
    isinf  = (ef == emf) && (man == 0);
    iszero = (ef == 0) && (man == 0);
    if (ef != 0) man = man | (53'd1 << fb);
    e = (ef == 0) ? 1 - bias : ef - bias;
    case (md)
      4'd1, 4'd4: rm = 2'd0;
      4'd5: rm = 2'd1;
      4'd6: rm = 2'd2;
      4'd7: rm = 2'd3;
      default: rm = cur;
    endcase
    ecc = isnan ? 2'd3 : iszero ? 2'd0 : sg ? 2'd1 : 2'd2;
    maxv = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    minv = wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    einv = 1'b0; einx = 1'b0;
    if (isnan) begin
      val = minv; einv = 1'b1;
    end else if (isinf || e >= 64) begin
      val = sg ? minv : maxv; einv = 1'b1;
    end else begin
      if (e < -2) begin
        ip = '0; fr = (man != 0) ? 64'd1 : 64'd0;
      end else begin
        X = {75'b0, man} << (64 + e - fb);
        ip = X[127:64]; fr = X[63:0];
      end
      case (rm)
        2'd0: up = (fr > 64'h8000_0000_0000_0000) ||
                   ((fr == 64'h8000_0000_0000_0000) && ip[0]);
        2'd1: up = 1'b0;
        2'd2: up = (fr != 0) && !sg;
        default: up = (fr != 0) && sg;
      endcase
      mag = {1'b0, ip} + {64'b0, up};
      lim = wide ? (65'd1 << 63) : (65'd1 << 31);
      if (!sg) lim = lim - 65'd1;
      if (mag > lim) begin
        val = sg ? minv : maxv; einv = 1'b1;
      end else begin
        val = sg ? -mag[63:0] : mag[63:0];
        einx = (fr != 0);
      end
    end
    edst = wide ? val : {old[63:32], val[31:0]};
  endtask

  // Drive one conversion, wait for done, compare every field.
  task automatic run(input logic [63:0] s, input logic dbl, input logic wide,
                     input logic [3:0] md, input logic [1:0] cur, input logic [63:0] old,
                     input string req);
    logic [63:0] edst; logic [1:0] ecc; logic einv, einx;
    int cyc;
    ref_conv(s, dbl, wide, md, cur, old, edst, ecc, einv, einx);
    @(negedge clk);
    src = s; src_dbl = dbl; tgt_wide = wide; modifier = md; cur_rmode = cur; old_dst = old;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", {63'b0, busy}, 64'd1);
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 done within 68 cycles", {63'b0, (done && cyc <= 68)}, 64'd1);
    chk({req, " dst"}, dst, edst);
    chk("R5 cc", {62'b0, cc}, {62'b0, ecc});
    chk({req, " invalid"}, {63'b0, invalid}, {63'b0, einv});
    chk("R8 inexact", {63'b0, inexact}, {63'b0, einx});
    @(negedge clk);
    chk("R9 done pulse", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold_dst;
    logic [63:0] edst2; logic [1:0] ecc2; logic e_inv2, e_inx2;
    int cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", {63'b0, busy}, 64'd0);
    chk("R1 done", {63'b0, done}, 64'd0);
    chk("R1 dst", dst, 64'd0);
    chk("R1 flags", {60'b0, cc, invalid, inexact}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: every modifier against every current mode on a value with a fraction (-2.5)
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 4; c++)
        run(64'hC004_0000_0000_0000, 1'b1, 1'b1, 4'(m), 2'(c), 64'h0, "R2");

    // R3 R4: binary64 sweep over exponents, signs, widths and explicit modes
    for (int e = -3; e <= 66; e++)
      for (int p = 0; p < 2; p++)
        for (int sg = 0; sg < 2; sg++)
          for (int w = 0; w < 2; w++)
            for (int m = 4; m < 8; m++)
              run({1'(sg), 11'(e + 1023),
                   (p == 0) ? 52'h8_0000_0000_0000 : 52'hC_0000_0000_0001},
                  1'b1, 1'(w), 4'(m), 2'd0,
                  {32'hA5C3_0F1E ^ 32'(e), 32'h1234_5678}, (w == 0) ? "R4" : "R3");

    // R3: binary32 sweep, upper source half filled with junk
    for (int e = -3; e <= 66; e++)
      for (int sg = 0; sg < 2; sg++)
        for (int w = 0; w < 2; w++)
          for (int m = 4; m < 8; m++)
            run({32'hDEAD_BEEF, 1'(sg), 8'(e + 127),
                 (e % 2 == 0) ? 23'h40_0000 : 23'h20_0001},
                1'b0, 1'(w), 4'(m), 2'd0, 64'hFEDC_BA98_7654_3210, "R3");

    // R7: NaNs (quiet and signalling, both formats)
    run(64'h7FF8_0000_0000_0000, 1'b1, 1'b1, 4'd0, 2'd0, 64'h0, "R7");
    run(64'hFFF0_0000_0000_0001, 1'b1, 1'b0, 4'd5, 2'd0, 64'h1111_2222_3333_4444, "R7");
    run(64'h0000_0000_7FC0_0000, 1'b0, 1'b0, 4'd0, 2'd0, 64'h5555_6666_7777_8888, "R7");
    // R6: infinities and exact range edges
    run(64'h7FF0_0000_0000_0000, 1'b1, 1'b1, 4'd0, 2'd0, 64'h0, "R6");
    run(64'h0000_0000_FF80_0000, 1'b0, 1'b0, 4'd0, 2'd0, 64'hAAAA_BBBB_0000_0000, "R6");
    run(64'hC3E0_0000_0000_0000, 1'b1, 1'b1, 4'd5, 2'd0, 64'h0, "R6");  // -2^63 fits
    run(64'h43E0_0000_0000_0000, 1'b1, 1'b1, 4'd5, 2'd0, 64'h0, "R6");  // 2^63 overflows
    run(64'hC1E0_0000_0000_0000, 1'b1, 1'b0, 4'd5, 2'd0, 64'h0, "R6");  // -2^31 fits
    run(64'h41E0_0000_0000_0000, 1'b1, 1'b0, 4'd5, 2'd0, 64'h0, "R6");  // 2^31 overflows
    run(64'hC1E0_0000_0010_0000, 1'b1, 1'b0, 4'd5, 2'd0, 64'h0, "R6");  // -2^31-0.5 toward zero
    run(64'hC1E0_0000_0010_0000, 1'b1, 1'b0, 4'd4, 2'd0, 64'h0, "R6");  // tie to even
    run(64'h41DF_FFFF_FFE0_0000, 1'b1, 1'b0, 4'd4, 2'd0, 64'h0, "R6");  // 2^31-0.5 rounds out
    // R5 R8: zeros and denormals
    run(64'h0000_0000_0000_0000, 1'b1, 1'b1, 4'd0, 2'd0, 64'h0, "R5");
    run(64'h8000_0000_0000_0000, 1'b1, 1'b0, 4'd7, 2'd0, 64'h9999_0000_0000_0000, "R5");
    run(64'h8000_0000_0000_0001, 1'b1, 1'b1, 4'd7, 2'd0, 64'h0, "R8");  // tiny negative -> -1
    run(64'h0000_0000_0000_0001, 1'b0, 1'b0, 4'd6, 2'd0, 64'h0, "R8");  // tiny positive -> 1

    // R10: a second start while busy is ignored
    ref_conv(64'h3FF8_0000_0000_0000, 1'b1, 1'b1, 4'd5, 2'd0, 64'h0, edst2, ecc2, e_inv2, e_inx2);
    @(negedge clk);
    src = 64'h3FF8_0000_0000_0000; src_dbl = 1'b1; tgt_wide = 1'b1; modifier = 4'd5; old_dst = '0;
    start = 1'b1;
    @(negedge clk);
    src = 64'hC059_0000_0000_0000; modifier = 4'd6; tgt_wide = 1'b0; old_dst = '1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10 first operands win", dst, edst2);
    chk("R10 cc of first operand", {62'b0, cc}, {62'b0, ecc2});
    hold_dst = dst;
    cyc = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) cyc++;
    end
    chk("R10 no extra done", 64'(cyc), 64'd0);
    // R11: outputs hold while idle
    chk("R11 dst held", dst, hold_dst);
    chk("R11 cc held", {62'b0, cc}, {62'b0, ecc2});

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule